// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers five maskable interrupt conditions of a small 8-bit computer's system logic and presents them to the processor as one active-high interrupt request. The conditions are a frame-bottom vertical sync, a periodic real-time tick, a serial transmitter that has become empty, a serial receiver that has become full, and a detected cassette high tone. Each condition has a sticky pending flag. An enable mask, written by software, selects which pending flags drive the request line.

Software reaches the block through a simple register port. A status register reports the request state and the pending flags, and writing it loads the enable mask. A separate clear register acknowledges conditions one bit at a time. Its top bit also acknowledges a non-maskable interrupt: while that interrupt is raised, video memory fetches are held off, and the hold lasts until software acknowledges. The vertical-sync condition comes from the scanline counter. It is raised when the counter enters the last displayed line and dropped by hardware when the counter returns to line zero.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, all pending flags, the enable mask and the memory-suspend hold are zero, so `irq_out` and `mem_suspend` are low.
- R2: A one-cycle strobe on `rtc_tick`, `tx_empty`, `rx_full` or `tone_hi` sets that source's pending flag on the next clock edge. Pending bit positions in the status and clear registers are: vsync bit 2, tick bit 3, transmit-empty bit 4, receive-full bit 5, high-tone bit 6.
- R3: Writing the status register (offset 0) loads the enable mask from bits 2..6. `irq_out` is high exactly when some pending flag has its enable bit set.
- R4: Reading offset 0 returns bit 0 = `irq_out`, bits 2..6 = pending flags, bits 1 and 7 = 0. Reads of any other offset, or with `bus_sel` low, return 0.
- R5: Writing the clear register (offset 5) with a 1 in a source's bit clears that pending flag. A 0 bit leaves the flag unchanged.
- R6: When a source strobe and a clear of that same source happen in the same cycle, the flag ends up set.
- R7: The vsync flag is set when `scanline` changes to LAST_LINE. It is cleared when `scanline` changes to 0, whether or not software has acknowledged it.
- R8: `nmi_in` high sets `mem_suspend` on the next edge. The hold stays set until the clear register is written with bit 7 = 1 while `nmi_in` is low. An acknowledge while `nmi_in` is high has no effect.
- R9: Writes to the clear register do not change the enable mask. Writes to the status register do not change the pending flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset within the block |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| scanline | input | LINE_W | Current scanline counter |
| rtc_tick | input | 1 | Real-time tick strobe |
| tx_empty | input | 1 | Serial transmit-empty strobe |
| rx_full | input | 1 | Serial receive-full strobe |
| tone_hi | input | 1 | Cassette high-tone strobe |
| nmi_in | input | 1 | Non-maskable interrupt level |
| irq_out | output | 1 | Maskable interrupt request, active high |
| mem_suspend | output | 1 | Video memory access held off |

## Verification
The bench builds the block with LINE_W = 9 and LAST_LINE = 12, so the scanline can be walked up to the final displayed line and back to zero in a few dozen cycles. Both vsync edges, and a software clear between them, are therefore exercised in one short run. The register offsets keep their defaults (status 0, clear 5), and a spare offset is read to confirm that it returns zero.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_SRC = 5;
    localparam int DATA_W  = 8;

    // Source index within the pending vector (bit 0 of the vector = vsync)
    typedef enum logic [2:0] {
        SRC_VSYNC = 3'd0,
        SRC_TICK  = 3'd1,
        SRC_TXE   = 3'd2,
        SRC_RXF   = 3'd3,
        SRC_TONE  = 3'd4
    } src_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        logic              status_rd;
        logic              status_wr;
        logic              clear_wr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // Place the pending vector and the active flag into a status byte
    function automatic logic [DATA_W-1:0] pack_status(input src_vec_t pend,
                                                      input logic active,
                                                      input int unsigned first);
        logic [DATA_W-1:0] r;
        r = DATA_W'(pend) << first;
        r = r | DATA_W'(active);
        return r;
    endfunction

    // Extract the per-source field of a written byte
    function automatic src_vec_t field_of(input logic [DATA_W-1:0] d,
                                          input int unsigned first);
        return src_vec_t'(d >> first);
    endfunction

endpackage

// File: rtl/irqc_bus_decode.sv
module irqc_bus_decode
    import irqc_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int STATUS_OFS = 0,
    parameter int CLEAR_OFS  = 5
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output bus_req_t          req
);
    localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_OFS);
    localparam logic [ADDR_W-1:0] CLEAR_A  = ADDR_W'(CLEAR_OFS);

    always_comb begin
        req.status_rd = sel && !wr && (addr == STATUS_A);
        req.status_wr = sel &&  wr && (addr == STATUS_A);
        req.clear_wr  = sel &&  wr && (addr == CLEAR_A);
        req.wdata     = wdata;
    end
endmodule

// File: rtl/irqc_line_watch.sv
module irqc_line_watch #(
    parameter int LINE_W    = 9,
    parameter int LAST_LINE = 255
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] scanline,
    output logic              enter_last,
    output logic              enter_zero
);
    localparam logic [LINE_W-1:0] LAST_V = LINE_W'(LAST_LINE);

    logic [LINE_W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= scanline;
    end

    assign enter_last = (scanline == LAST_V) && (prev_q != LAST_V);
    assign enter_zero = (scanline == '0)     && (prev_q != '0);
endmodule

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t set_i,
    input  src_vec_t clr_i,
    input  logic     en_wr,
    input  src_vec_t en_data,
    output src_vec_t pend_o,
    output src_vec_t en_o,
    output logic     irq_o
);
    src_vec_t en_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk) begin
            if (rst)           flag_q <= 1'b0;
            else if (set_i[i]) flag_q <= 1'b1;   // event beats acknowledge
            else if (clr_i[i]) flag_q <= 1'b0;
        end
        assign pend_o[i] = flag_q;
    end

    always_ff @(posedge clk) begin
        if (rst)        en_q <= '0;
        else if (en_wr) en_q <= en_data;
    end

    assign en_o  = en_q;
    assign irq_o = |(pend_o & en_q);
endmodule

// File: rtl/irqc_nmi_hold.sv
module irqc_nmi_hold (
    input  logic clk,
    input  logic rst,
    input  logic nmi_i,
    input  logic ack_i,
    output logic hold_o
);
    logic hold_q;

    always_ff @(posedge clk) begin
        if (rst)        hold_q <= 1'b0;
        else if (nmi_i) hold_q <= 1'b1;
        else if (ack_i) hold_q <= 1'b0;
    end

    assign hold_o = hold_q;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irqc_pkg::*;
#(
    parameter int ADDR_W        = 4,
    parameter int STATUS_OFS    = 0,
    parameter int CLEAR_OFS     = 5,
    parameter int LINE_W        = 9,
    parameter int LAST_LINE     = 255,
    parameter int FIRST_SRC_BIT = 2,
    parameter int NMI_ACK_BIT   = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [LINE_W-1:0] scanline,
    input  logic              rtc_tick,
    input  logic              tx_empty,
    input  logic              rx_full,
    input  logic              tone_hi,
    input  logic              nmi_in,
    output logic              irq_out,
    output logic              mem_suspend
);
    bus_req_t req_w;
    logic     enter_last_w;
    logic     enter_zero_w;
    src_vec_t set_w;
    src_vec_t clr_w;
    src_vec_t wfield_w;
    src_vec_t pend_w;
    src_vec_t en_w;
    logic     irq_w;
    logic     nmi_ack_w;

    irqc_bus_decode #(
        .ADDR_W    (ADDR_W),
        .STATUS_OFS(STATUS_OFS),
        .CLEAR_OFS (CLEAR_OFS)
    ) u_dec (
        .sel  (bus_sel),
        .wr   (bus_wr),
        .addr (bus_addr),
        .wdata(bus_wdata),
        .req  (req_w)
    );

    irqc_line_watch #(
        .LINE_W   (LINE_W),
        .LAST_LINE(LAST_LINE)
    ) u_line (
        .clk       (clk),
        .rst       (rst),
        .scanline  (scanline),
        .enter_last(enter_last_w),
        .enter_zero(enter_zero_w)
    );

    assign wfield_w = field_of(req_w.wdata, FIRST_SRC_BIT);

    always_comb begin
        set_w                 = '0;
        set_w[int'(SRC_VSYNC)] = enter_last_w;
        set_w[int'(SRC_TICK)]  = rtc_tick;
        set_w[int'(SRC_TXE)]   = tx_empty;
        set_w[int'(SRC_RXF)]   = rx_full;
        set_w[int'(SRC_TONE)]  = tone_hi;

        clr_w = req_w.clear_wr ? wfield_w : '0;
        clr_w[int'(SRC_VSYNC)] = clr_w[int'(SRC_VSYNC)] | enter_zero_w;
    end

    irqc_flag_bank u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_w),
        .clr_i  (clr_w),
        .en_wr  (req_w.status_wr),
        .en_data(wfield_w),
        .pend_o (pend_w),
        .en_o   (en_w),
        .irq_o  (irq_w)
    );

    assign nmi_ack_w = req_w.clear_wr && req_w.wdata[NMI_ACK_BIT];

    irqc_nmi_hold u_nmi (
        .clk   (clk),
        .rst   (rst),
        .nmi_i (nmi_in),
        .ack_i (nmi_ack_w),
        .hold_o(mem_suspend)
    );

    assign irq_out   = irq_w;
    assign bus_rdata = req_w.status_rd ? pack_status(pend_w, irq_w, FIRST_SRC_BIT)
                                       : '0;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int ADDR_W        = 4,
    parameter int STATUS_OFS    = 0,
    parameter int CLEAR_OFS     = 5,
    parameter int LINE_W        = 9,
    parameter int LAST_LINE     = 255,
    parameter int FIRST_SRC_BIT = 2,
    parameter int NMI_ACK_BIT   = 7,
    parameter int NSRC          = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic [LINE_W-1:0] scanline,
    input logic              rtc_tick,
    input logic              tx_empty,
    input logic              rx_full,
    input logic              tone_hi,
    input logic              nmi_in,
    input logic              irq_out,
    input logic              mem_suspend,
    input logic [NSRC-1:0]   pend,
    input logic [NSRC-1:0]   en
);
    localparam logic [ADDR_W-1:0] ST_A  = ADDR_W'(STATUS_OFS);
    localparam logic [ADDR_W-1:0] CL_A  = ADDR_W'(CLEAR_OFS);
    localparam logic [LINE_W-1:0] LASTV = LINE_W'(LAST_LINE);

    logic [NSRC-2:0] evt;
    logic [NSRC-1:0] clr_bits;
    logic            clr_wr;
    logic            st_wr;
    logic            st_rd;

    assign evt      = {tone_hi, rx_full, tx_empty, rtc_tick};
    assign clr_bits = NSRC'(bus_wdata >> FIRST_SRC_BIT);
    assign clr_wr   = bus_sel && bus_wr && (bus_addr == CL_A);
    assign st_wr    = bus_sel && bus_wr && (bus_addr == ST_A);
    assign st_rd    = bus_sel && !bus_wr && (bus_addr == ST_A);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!irq_out && !mem_suspend));

    // also covers R6: a strobe wins over a same-cycle clear
    assert_strobe_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((pend[NSRC-1:1] & $past(evt)) == $past(evt)));

    assert_read_irq_bit_R4: assert property (@(posedge clk) disable iff (rst)
        st_rd |-> (bus_rdata[0] == irq_out));

    assert_clear_drops_R5: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !(|evt)) |=> ((pend[NSRC-1:1] & $past(clr_bits[NSRC-1:1])) == '0));

    assert_vsync_enter_R7: assert property (@(posedge clk) disable iff (rst)
        (scanline == LASTV && $past(scanline) != LASTV) |=> pend[0]);

    assert_vsync_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (scanline == '0 && $past(scanline) != '0) |=> !pend[0]);

    assert_nmi_holds_R8: assert property (@(posedge clk) disable iff (rst)
        nmi_in |=> mem_suspend);

    assert_hold_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_suspend && !nmi_in && !(clr_wr && bus_wdata[NMI_ACK_BIT])) |=> mem_suspend);

    assert_mask_kept_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !st_wr) |=> $stable(en));
endmodule

bind irq_status_ctrl irqc_checker #(
    .ADDR_W       (ADDR_W),
    .STATUS_OFS   (STATUS_OFS),
    .CLEAR_OFS    (CLEAR_OFS),
    .LINE_W       (LINE_W),
    .LAST_LINE    (LAST_LINE),
    .FIRST_SRC_BIT(FIRST_SRC_BIT),
    .NMI_ACK_BIT  (NMI_ACK_BIT),
    .NSRC         (irqc_pkg::NUM_SRC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .scanline   (scanline),
    .rtc_tick   (rtc_tick),
    .tx_empty   (tx_empty),
    .rx_full    (rx_full),
    .tone_hi    (tone_hi),
    .nmi_in     (nmi_in),
    .irq_out    (irq_out),
    .mem_suspend(mem_suspend),
    .pend       (pend_w),
    .en         (en_w)
);

// File: tb/sim_irq_status_ctrl.sv
module sim_irq_status_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;
    localparam int LINE_W     = 9;
    localparam int LAST_LINE  = 12;
    localparam int WATCHDOG   = 20000;

    localparam logic [7:0] B_VS = 8'h04, B_TK = 8'h08, B_TX = 8'h10,
                           B_RX = 8'h20, B_TN = 8'h40, B_ALL = 8'h7C;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic [LINE_W-1:0] scanline = '0;
    logic              rtc_tick = 1'b0, tx_empty = 1'b0, rx_full = 1'b0, tone_hi = 1'b0;
    logic              nmi_in = 1'b0;
    logic              irq_out, mem_suspend;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_ctrl #(
        .ADDR_W   (ADDR_W),
        .LINE_W   (LINE_W),
        .LAST_LINE(LAST_LINE)
    ) u0 (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .scanline(scanline),
        .rtc_tick(rtc_tick), .tx_empty(tx_empty), .rx_full(rx_full), .tone_hi(tone_hi),
        .nmi_in(nmi_in), .irq_out(irq_out), .mem_suspend(mem_suspend)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got 0x%02h expected 0x%02h", req, what, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic bus_write(input int a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        step();
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input int a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(a);
        #1 d = bus_rdata;
        step();
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input int which);
        case (which)
            1: rtc_tick = 1'b1;
            2: tx_empty = 1'b1;
            3: rx_full  = 1'b1;
            default: tone_hi = 1'b1;
        endcase
        step();
        rtc_tick = 1'b0; tx_empty = 1'b0; rx_full = 1'b0; tone_hi = 1'b0;
    endtask

    task automatic set_line(input int v);
        scanline = LINE_W'(v);
        step();
    endtask

    task automatic status_is(input string req, input string what, input logic [7:0] exp);
        logic [7:0] d;
        bus_read(0, d);
        chk(req, what, d, exp);
    endtask

    task automatic t_reset();
        chk("R1", "irq after reset", {7'd0, irq_out}, 8'h00);
        chk("R1", "suspend after reset", {7'd0, mem_suspend}, 8'h00);
        status_is("R1", "status after reset", 8'h00);
    endtask

    task automatic t_sources();
        pulse(1); status_is("R2", "tick pending", B_TK); bus_write(5, B_TK);
        pulse(2); status_is("R2", "tx pending", B_TX);   bus_write(5, B_TX);
        pulse(3); status_is("R2", "rx pending", B_RX);   bus_write(5, B_RX);
        pulse(4); status_is("R2", "tone pending", B_TN); bus_write(5, B_TN);
        status_is("R2", "all cleared", 8'h00);
    endtask

    task automatic t_mask();
        bus_write(0, B_RX);
        pulse(4);
        chk("R3", "masked tone keeps irq low", {7'd0, irq_out}, 8'h00);
        status_is("R3", "masked tone visible", B_TN);
        pulse(3);
        chk("R3", "enabled rx raises irq", {7'd0, irq_out}, 8'h01);
        status_is("R3", "status with irq", B_TN | B_RX | 8'h01);
        bus_write(0, 8'h00);
        chk("R3", "mask off drops irq", {7'd0, irq_out}, 8'h00);
        bus_write(5, B_ALL);
    endtask

    task automatic t_format();
        logic [7:0] d;
        bus_write(0, B_ALL);
        pulse(1);
        status_is("R4", "status format", B_TK | 8'h01);
        bus_read(5, d); chk("R4", "clear reg read", d, 8'h00);
        bus_read(3, d); chk("R4", "spare offset read", d, 8'h00);
        bus_addr = '0; #1;
        chk("R4", "deselected read", bus_rdata, 8'h00);
        step();
        bus_write(5, B_ALL);
    endtask

    task automatic t_clear();
        pulse(1); pulse(2); pulse(3);
        bus_write(5, B_TX);
        status_is("R5", "one bit cleared", B_TK | B_RX | 8'h01);
        bus_write(5, 8'h00);
        status_is("R5", "zero write no effect", B_TK | B_RX | 8'h01);
        bus_write(5, B_TK | B_RX);
        status_is("R5", "rest cleared", 8'h00);
        chk("R5", "irq low after clear", {7'd0, irq_out}, 8'h00);
    endtask

    task automatic t_collision();
        rtc_tick = 1'b1;
        bus_write(5, B_TK);
        rtc_tick = 1'b0;
        status_is("R6", "strobe beats clear", B_TK | 8'h01);
        bus_write(5, B_ALL);
    endtask

    task automatic t_vsync();
        for (int v = 1; v < LAST_LINE; v++) set_line(v);
        status_is("R7", "before last line", 8'h00);
        set_line(LAST_LINE);
        status_is("R7", "last line sets vsync", B_VS | 8'h01);
        chk("R7", "vsync irq", {7'd0, irq_out}, 8'h01);
        set_line(LAST_LINE + 1);
        set_line(0);
        status_is("R7", "wrap clears vsync", 8'h00);
        for (int v = 1; v <= LAST_LINE; v++) set_line(v);
        bus_write(5, B_VS);
        status_is("R7", "software clears vsync", 8'h00);
        set_line(0);
    endtask

    task automatic t_nmi();
        nmi_in = 1'b1; step(); nmi_in = 1'b0;
        chk("R8", "nmi sets suspend", {7'd0, mem_suspend}, 8'h01);
        step();
        chk("R8", "suspend sticky", {7'd0, mem_suspend}, 8'h01);
        bus_write(5, B_ALL);
        chk("R8", "no ack bit keeps suspend", {7'd0, mem_suspend}, 8'h01);
        nmi_in = 1'b1;
        bus_write(5, 8'h80);
        nmi_in = 1'b0;
        chk("R8", "ack during nmi ignored", {7'd0, mem_suspend}, 8'h01);
        bus_write(5, 8'h80);
        chk("R8", "ack releases suspend", {7'd0, mem_suspend}, 8'h00);
    endtask

    task automatic t_isolation();
        bus_write(0, B_RX);
        bus_write(5, 8'hFC);
        pulse(3);
        chk("R9", "clear write kept mask", {7'd0, irq_out}, 8'h01);
        bus_write(0, 8'h00);
        status_is("R9", "status write kept pending", B_RX);
        bus_write(5, B_ALL);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_sources();
        t_mask();
        t_format();
        t_clear();
        t_collision();
        t_vsync();
        t_nmi();
        t_isolation();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule